// File: doc/BRIEF.md
# Two-Party Sequenced Enable Interlock

This block releases a single enable pulse only after two operators have each completed their own ordered two-button sequence. Operator one works buttons A then B; operator two works buttons C then D. Each operator is followed by a private state machine. That machine waits on its first button and then on its second. It may wait any number of cycles on either button. Both machines are armed together by one start pulse and run side by side. A join stage watches both machines. Once both have finished, it issues one enable pulse and one finish pulse in the same cycle, and then returns the whole block to idle.

Button levels are assumed to be clean and synchronous to the clock. Debouncing, synchronisers and timeouts belong to the surrounding logic. After each pulse the block needs a new start pulse before it accepts button presses again.

Top module: `two_party_interlock`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `enable_o` and `finish_o` are low. The block comes out of reset idle.
- R2: Operator one's side completes only when A (bit 0 of that side's key vector) is seen high and B (bit 1) is seen high in a later cycle. Operator two follows the same rule with C then D.
- R3: A press of the second button of a side before that side has seen its first button is ignored. The side keeps waiting for its first button.
- R4: Any number of cycles may pass between the first and second press of one operator.
- R5: The enable pulse is issued only when both sides have completed. A side that completes first holds its completion until the other side finishes.
- R6: `enable_o` is high for exactly one cycle. A button sampled at clock edge t that completes the later of the two sides raises `enable_o` after edge t+1. `enable_o` is low at every other time.
- R7: `finish_o` is high in exactly the same cycles as `enable_o`.
- R8: While idle, button presses have no effect. A start pulse while the sides are armed has no effect and does not discard progress.
- R9: After the enable pulse, both sides are idle again. Button presses without a new start pulse produce no further pulse.
- R10: The two sides progress independently. Their presses may interleave in any order or fall in the same cycle.
- R11: A synchronous reset in the middle of a sequence discards all progress of both sides and of the join.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Arms both sides when the block is idle |
| btn_a_i | input | 1 | Operator one, first button level |
| btn_b_i | input | 1 | Operator one, second button level |
| btn_c_i | input | 1 | Operator two, first button level |
| btn_d_i | input | 1 | Operator two, second button level |
| enable_o | output | 1 | One-cycle enable pulse |
| finish_o | output | 1 | One-cycle completion pulse, coincident with enable |

## Verification
The join is tested with three press orders: the sides interleaved, pressed simultaneously, and one side finishing about fifty cycles ahead of the other. These orders separate a correct join from one that fires on a single side, and they confirm that the pulse timing tracks the later side. Out-of-order presses followed by first buttons only show whether a second button was wrongly counted. Presses before start, after the pulse, and after a mid-sequence reset show whether the idle state really ignores the buttons. A repeated start in mid-sequence shows whether arming is wrongly re-entered and progress discarded.

// File: rtl/interlock_pkg.sv
package interlock_pkg;
  localparam int unsigned SIDES = 2;
  localparam int unsigned STEPS = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_t;
endpackage

// File: rtl/interlock_side.sv
module interlock_side
  import interlock_pkg::*;
#(
  parameter int unsigned STEPS_P = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               arm_i,
  input  logic               clear_i,
  input  logic [STEPS_P-1:0] keys_i,
  output logic               idle_o,
  output logic               done_o
);
  localparam int unsigned IW = (STEPS_P > 1) ? $clog2(STEPS_P) : 1;
  localparam logic [IW-1:0] LAST = IW'(STEPS_P - 1);

  phase_t        phase_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (arm_i) begin
            phase_q <= PH_RUN;
            idx_q   <= '0;
          end
        end
        PH_RUN: begin
          if (keys_i[idx_q]) begin
            if (idx_q == LAST) phase_q <= PH_DONE;
            else               idx_q   <= idx_q + 1'b1;
          end
        end
        PH_DONE: begin
          if (clear_i) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign idle_o = (phase_q == PH_IDLE);
  assign done_o = (phase_q == PH_DONE);
endmodule

// File: rtl/interlock_join.sv
module interlock_join #(
  parameter int unsigned SIDES_P = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SIDES_P-1:0] done_i,
  output logic               all_done_o,
  output logic               enable_o,
  output logic               finish_o
);
  assign all_done_o = &done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_o <= 1'b0;
      finish_o <= 1'b0;
    end else begin
      enable_o <= all_done_o;
      finish_o <= all_done_o;
    end
  end
endmodule

// File: rtl/two_party_interlock.sv
module two_party_interlock
  import interlock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic btn_a_i,
  input  logic btn_b_i,
  input  logic btn_c_i,
  input  logic btn_d_i,
  output logic enable_o,
  output logic finish_o
);
  logic [SIDES-1:0][STEPS-1:0] side_keys;
  logic [SIDES-1:0]            side_idle;
  logic [SIDES-1:0]            side_done;
  logic                        all_idle;
  logic                        all_done;
  logic                        arm;

  assign side_keys[0] = {btn_b_i, btn_a_i};
  assign side_keys[1] = {btn_d_i, btn_c_i};

  assign all_idle = &side_idle;
  assign arm      = start_i & all_idle;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    interlock_side #(.STEPS_P(STEPS)) u_side (
      .clk     (clk),
      .rst     (rst),
      .arm_i   (arm),
      .clear_i (all_done),
      .keys_i  (side_keys[s]),
      .idle_o  (side_idle[s]),
      .done_o  (side_done[s])
    );
  end

  interlock_join #(.SIDES_P(SIDES)) u_join (
    .clk        (clk),
    .rst        (rst),
    .done_i     (side_done),
    .all_done_o (all_done),
    .enable_o   (enable_o),
    .finish_o   (finish_o)
  );
endmodule

// File: rtl/interlock_chk.sv
module interlock_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       btn_b_i,
  input logic       btn_d_i,
  input logic       enable_o,
  input logic [1:0] side_done,
  input logic       all_idle
);
  // R6: the pulse never lasts two cycles
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    enable_o |=> !enable_o);

  // R5: the pulse follows a cycle where both sides were complete
  p_join_both_r5: assert property (@(posedge clk) disable iff (rst)
    enable_o |-> $past(&side_done));

  // R5: a lone finished side keeps its completion
  p_hold_side0_r5: assert property (@(posedge clk) disable iff (rst)
    (side_done[0] && !side_done[1]) |=> side_done[0]);

  // R2: a side completes only on its second button
  p_order_side0_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(side_done[0]) |-> $past(btn_b_i));
  p_order_side1_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(side_done[1]) |-> $past(btn_d_i));

  // R9: the block is idle while the pulse is out
  p_idle_after_r9: assert property (@(posedge clk) disable iff (rst)
    enable_o |-> all_idle);

  // R8: without start, idle persists
  p_stay_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (all_idle && !start_i) |=> all_idle);
endmodule

bind two_party_interlock interlock_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .btn_b_i   (btn_b_i),
  .btn_d_i   (btn_d_i),
  .enable_o  (enable_o),
  .side_done (side_done),
  .all_idle  (all_idle)
);

// File: tb/two_party_interlock_tb.sv
module two_party_interlock_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic btn_a_i = 1'b0, btn_b_i = 1'b0, btn_c_i = 1'b0, btn_d_i = 1'b0;
  logic enable_o, finish_o;

  int unsigned cyc = 0;
  int checks = 0;
  int fails = 0;
  int unsigned exp_q[$];
  bit done_flag = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  two_party_interlock u_dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .btn_a_i(btn_a_i), .btn_b_i(btn_b_i), .btn_c_i(btn_c_i), .btn_d_i(btn_d_i),
    .enable_o(enable_o), .finish_o(finish_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // drive inputs at the falling edge; sampled at the next rising edge
  task automatic drive(input logic s, input logic a, input logic b,
                       input logic c, input logic d);
    @(negedge clk);
    start_i = s; btn_a_i = a; btn_b_i = b; btn_c_i = c; btn_d_i = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
  endtask

  // called right after driving the press that completes the later side
  task automatic expect_pulse();
    exp_q.push_back(cyc + 2);
  endtask

  // no pulse may appear during the next n cycles
  task automatic quiet(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      drive(0, 0, 0, 0, 0);
      if (enable_o) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  // monitor: every pulse is compared with the scoreboard queue
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      if (enable_o || finish_o)
        chk(enable_o == finish_o, "R7 finish coincides with enable", finish_o, enable_o);
      if (enable_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected enable pulse", 1, 0);
        end else begin
          int unsigned e;
          e = exp_q.pop_front();
          chk(cyc == e, "R6 enable pulse cycle", cyc, e);
        end
      end else if (exp_q.size() != 0 && cyc > exp_q[0]) begin
        int unsigned e;
        e = exp_q.pop_front();
        chk(1'b0, "R5 expected enable pulse missing", 0, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(enable_o == 1'b0, "R1 enable low in reset", enable_o, 0);
    chk(finish_o == 1'b0, "R1 finish low in reset", finish_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(enable_o == 1'b0 && finish_o == 1'b0, "R1 outputs low after reset", enable_o, 0);

    // R8: buttons while idle are ignored
    drive(0, 1, 0, 0, 0); drive(0, 0, 1, 0, 0);
    drive(0, 0, 0, 1, 0); drive(0, 0, 0, 0, 1);
    quiet(5, "R8 no pulse from presses before start");

    // R2 R6: interleaved basic sequence
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 0, 0, 0);
    drive(0, 0, 0, 1, 0);
    drive(0, 0, 1, 0, 0);
    idle(2);
    drive(0, 0, 0, 0, 1); expect_pulse();
    idle(6);
    chk(exp_q.size() == 0, "R2 interleaved sequence pulse", exp_q.size(), 0);

    // R3: second buttons first are ignored
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 1);
    drive(0, 1, 0, 1, 0);
    quiet(6, "R3 early second buttons not counted");
    drive(0, 0, 1, 0, 1); expect_pulse();
    idle(6);
    chk(exp_q.size() == 0, "R3 pulse after proper order", exp_q.size(), 0);

    // R4 R5 R10: side two done long before side one
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 0, 1, 0);
    drive(0, 0, 0, 0, 1);
    quiet(50, "R5 one side alone gives no pulse");
    drive(0, 0, 1, 0, 0); expect_pulse();
    idle(6);
    chk(exp_q.size() == 0, "R4 long pause still completes", exp_q.size(), 0);

    // R8: start while armed keeps progress
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 0, 1, 0);
    drive(1, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 1); expect_pulse();
    idle(6);
    chk(exp_q.size() == 0, "R8 restart ignored while armed", exp_q.size(), 0);

    // R9: no re-arm without start
    drive(0, 1, 0, 1, 0);
    drive(0, 0, 1, 0, 1);
    quiet(5, "R9 no pulse without new start");

    // R10: simultaneous presses
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 0, 1, 0);
    drive(0, 0, 1, 0, 1); expect_pulse();
    idle(6);
    chk(exp_q.size() == 0, "R10 simultaneous sides complete", exp_q.size(), 0);

    // R11: reset mid-sequence
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 0, 1, 0);
    drive(0, 0, 1, 0, 0);
    @(negedge clk); rst = 1'b1; btn_b_i = 1'b0;
    @(negedge clk); rst = 1'b0;
    drive(0, 0, 0, 0, 1);
    quiet(5, "R11 reset discards progress");
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 0, 1, 0);
    drive(0, 0, 1, 0, 1); expect_pulse();
    idle(6);
    chk(exp_q.size() == 0, "R11 fresh sequence after reset", exp_q.size(), 0);

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule